// File: doc/BRIEF.md
# Multichannel Hit Timestamp Capture

This block timestamps discriminator hits from a bank of detector channels. Each hit line is asynchronous to the fast sampling clock, so it first passes through a two-flop synchronizer. A rising-edge detector follows the synchronizer. All channels share one free-running timer. When a channel shows a new rising edge, the current timer value is written into that channel's own stamp register. The channel is then marked pending.

A fixed-priority arbiter moves one pending channel per cycle into a record FIFO, lowest channel number first. Readout uses a valid/ready stream. Each record holds the channel number and a reduced timestamp. The reduced timestamp drops the low `SHIFT` timer bits to set a coarser time unit. It keeps only `OW` bits above them, and `OW` is chosen so that the field cannot wrap within the worst-case readout latency.

A channel that fires again while its earlier capture has not yet reached the FIFO loses the new hit. Its sticky overflow flag is then raised. The channel count, timer width, resolution shift, stamp width and FIFO depth are all parameters.

Top module: `hit_stamp_capture`

## Requirements
- R1: In the cycle after a synchronous active-high reset, `rec_valid` is 0 and every bit of `ovf_flags` is 0. The shared timer restarts from 0.
- R2: Each 0-to-1 transition of a hit line gives exactly one record. A line held high gives one record. A falling transition gives none.
- R3: The raw timer value captured for a hit equals N+2. N is the number of rising clock edges since reset release, counted up to the last edge before the hit line went high. The line is assumed to change between clock edges.
- R4: `rec_data` is `{channel, stamp}`. The channel number is in the upper `CW` bits. `stamp` is in the low `OW` bits and equals bits `[SHIFT+OW-1:SHIFT]` of the captured raw timer value.
- R5: When several channels rise in the same cycle, their records leave in ascending channel order.
- R6: A rising edge on a channel whose previous capture is still pending (not yet moved into the FIFO) is dropped. That channel's bit in `ovf_flags` is set and stays set until reset. The earlier record for that channel is unchanged.
- R7: While `rec_valid` is high and `rec_ready` is low, `rec_valid` stays high and `rec_data` stays stable. When the FIFO is full, captured records wait in their channel registers and are not lost.
- R8: Records for hits captured in different cycles leave in capture order, provided none of them had to wait in a channel register.
- R9: The timer runs freely and wraps modulo 2^TW. The stamp field wraps modulo 2^OW.
- R10: Reset, applied at any time, discards every pending capture and every queued record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | NCH | Asynchronous discriminator outputs, one per channel |
| rec_valid | output | 1 | A record is available |
| rec_ready | input | 1 | Consumer accepts the record this cycle |
| rec_data | output | CW+OW | `{channel, stamp}` record |
| ovf_flags | output | NCH | Sticky per-channel flag for dropped re-fires |

## Verification
The bench builds the block with 12 channels, a 12-bit timer, a shift of 2, a 6-bit stamp and a FIFO depth of 4. With this small FIFO, six simultaneous hits fill the queue, which lets a channel be kept pending while it fires again. The short stamp field wraps every 256 cycles. The 12-bit timer wraps after 4096 cycles. Both wraps are therefore reached within a few thousand cycles of the run.

// File: rtl/hit_stamp_capture.sv
module hit_stamp_capture #(
  parameter int NCH   = 96,
  parameter int TW    = 16,
  parameter int SHIFT = 2,
  parameter int OW    = 9,
  parameter int DEPTH = 16
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NCH-1:0]                        hit_i,
  output logic                                  rec_valid,
  input  logic                                  rec_ready,
  output logic [((NCH>1)?$clog2(NCH):1)+OW-1:0] rec_data,
  output logic [NCH-1:0]                        ovf_flags
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int RW = CW + OW;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [NCH-1:0] sync_a, sync_b, sync_c, pend, ovf_q;
  logic [TW-1:0]  timer;
  logic [OW-1:0]  stamp [NCH];
  logic [CW-1:0]  sel;
  logic [RW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [AW:0]    cnt;

  wire [NCH-1:0] rise = sync_b & ~sync_c;
  wire           any  = |pend;
  wire           push = any && (cnt != (AW+1)'(DEPTH));
  wire           pop  = rec_valid && rec_ready;

  assign rec_valid = (cnt != '0);
  assign rec_data  = mem[rd_ptr];
  assign ovf_flags = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= '0;
      sync_b <= '0;
      sync_c <= '0;
      timer  <= '0;
    end else begin
      sync_a <= hit_i;
      sync_b <= sync_a;
      sync_c <= sync_b;
      timer  <= timer + 1'b1;
    end
  end

  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) sel = CW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      ovf_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (push && sel == CW'(i)) pend[i] <= 1'b0;
        if (rise[i]) begin
          if (pend[i]) ovf_q[i] <= 1'b1;
          else begin
            pend[i]  <= 1'b1;
            stamp[i] <= timer[SHIFT +: OW];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= {sel, stamp[sel]};
        wr_ptr      <= wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> timer == TW'($past(timer) + 1'b1)); // R9
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH)); // R7
  AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_data)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ovf_q & $past(ovf_q)) == $past(ovf_q)); // R6
  AST_OVF_ON_REFIRE: assert property (@(posedge clk) disable iff (rst)
    |(rise & pend) |=> (ovf_q & $past(rise & pend)) == $past(rise & pend)); // R6
  AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    push |=> !pend[$past(sel)]); // R5
endmodule

// File: tb/hit_stamp_capture_bench.sv
module hit_stamp_capture_bench;
  localparam int NCH = 12, TW = 12, SHIFT = 2, OW = 6, DEPTH = 4;
  localparam int CW = 4, RW = CW + OW;

  logic clk = 0, rst = 1, rdy = 0;
  logic [NCH-1:0] hit = '0;
  logic rec_valid;
  logic [RW-1:0] rec_data;
  logic [NCH-1:0] ovf;
  int cyc = 0, checks = 0, fails = 0;
  logic [RW-1:0] expq[$];
  logic [RW-1:0] held;

  always #4 clk = ~clk;

  hit_stamp_capture #(.NCH(NCH), .TW(TW), .SHIFT(SHIFT), .OW(OW), .DEPTH(DEPTH)) u_hit_stamp_capture (
    .clk(clk), .rst(rst), .hit_i(hit), .rec_valid(rec_valid), .rec_ready(rdy),
    .rec_data(rec_data), .ovf_flags(ovf));

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [NCH-1:0] m, input int hold, input bit want);
    int k;
    @(negedge clk);
    k = cyc;
    hit = hit | m;
    if (want)
      for (int i = 0; i < NCH; i++)
        if (m[i]) expq.push_back({CW'(i), OW'((k + 2) >> SHIFT)});
    repeat (hold) @(negedge clk);
    hit = hit & ~m;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: R2 R3 R4 R5 R8 R9
  always @(negedge clk) begin
    if (!rst && rec_valid && rdy) begin
      if (expq.size() == 0) chk(0, "R2 unexpected record", 32'(rec_data), 0);
      else begin
        held = expq.pop_front();
        chk(rec_data == held, "R3/R4/R5/R8/R9 record", 32'(rec_data), 32'(held));
      end
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(4);
    rst = 0;
    @(negedge clk);
    chk(rec_valid == 0, "R1 valid after reset", 32'(rec_valid), 0);
    chk(ovf == 0, "R1 flags after reset", 32'(ovf), 0);
    rdy = 1;

    fire(12'h008, 1, 1);            // R2 R3 single pulse
    idle(10);
    chk(expq.size() == 0, "R2 single pulse drained", expq.size(), 0);

    fire(12'h080, 25, 1);           // R2 held high: one record
    idle(10);
    chk(expq.size() == 0, "R2 held line one record", expq.size(), 0);

    fire(12'hA52, 1, 1);            // R5 simultaneous
    idle(12);
    chk(expq.size() == 0, "R5 simultaneous drained", expq.size(), 0);

    fire(12'h200, 1, 1);            // R8 capture order
    fire(12'h004, 1, 1);
    idle(10);
    chk(expq.size() == 0, "R8 order drained", expq.size(), 0);

    rdy = 0;                        // R7 R6 backpressure
    fire(12'h03F, 1, 1);
    idle(10);
    chk(rec_valid == 1, "R7 valid under backpressure", 32'(rec_valid), 1);
    chk(rec_data == expq[0], "R7 head record", 32'(rec_data), 32'(expq[0]));
    held = rec_data;
    idle(5);
    chk(rec_data == held && rec_valid, "R7 data stable", 32'(rec_data), 32'(held));
    fire(12'h010, 1, 0);            // channel 4 still pending: dropped
    idle(6);
    chk(ovf == 12'h010, "R6 overflow flag set", 32'(ovf), 32'h010);
    rdy = 1;
    idle(20);
    chk(expq.size() == 0, "R7 nothing lost", expq.size(), 0);
    chk(rec_valid == 0, "R6 no extra record", 32'(rec_valid), 0);
    chk(ovf == 12'h010, "R6 flag sticky", 32'(ovf), 32'h010);

    while (cyc < 300) @(negedge clk);
    fire(12'h800, 1, 1);            // R9 stamp wrap
    idle(10);
    while (cyc < 4093) @(negedge clk);
    fire(12'h002, 1, 1);            // R9 timer wrap
    idle(10);
    chk(expq.size() == 0, "R9 wrap drained", expq.size(), 0);

    rdy = 0;                        // R10 reset discards
    fire(12'h03F, 1, 0);
    idle(10);
    rst = 1;
    idle(2);
    rst = 0;
    @(negedge clk);
    chk(rec_valid == 0, "R10 queue cleared", 32'(rec_valid), 0);
    chk(ovf == 0, "R10 flags cleared", 32'(ovf), 0);
    rdy = 1;
    idle(10);
    chk(rec_valid == 0, "R10 pending cleared", 32'(rec_valid), 0);
    fire(12'h002, 1, 1);            // R1 timer restarted
    idle(10);
    chk(expq.size() == 0, "R1 post-reset record", expq.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule